// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus port of a parallel NOR-style flash controller and interprets every write cycle as a command. The low byte of the write data is the command code and the write address goes with it. Some codes act alone. Others open a two-cycle sequence whose second write decides the operation. The block keeps the status byte that the host reads. It also chooses whether a later read returns array contents or status. It never touches the array. Each decoded operation leaves the block as a one-cycle request with its address and data latched beside it.

A single setup code, 0x60, serves two families: the second write selects either a block protection change or a read-configuration update. A second write that fits no family sets both error flags. Program and erase suspend is tracked against a busy input and a program/erase kind input from a modelled write engine. A suspended operation stays suspended until it is resumed or the block is reset.

Top module: `flash_cmd_decoder`

## Requirements
- R1: During and after reset, with the engine idle, status reads 0x80, reads select array data (rd_status = 0) and every request output is low.
- R2: 0x60 followed by 0x01, 0xD0 or 0x2F pulses lock_req with lock_op 2'b01 (lock), 2'b10 (unlock) or 2'b11 (lock-down). lock_addr holds the address of the second write and reads then select status.
- R3: 0x60 followed by 0x03 pulses rcr_wr with rcr_val equal to address bits [16:1] of the second write, and reads then select array data.
- R4: After 0x60 or 0xBC, a second write that is not an accepted follow-on code sets status bits 5 and 4 together, issues no request, and makes reads select status.
- R5: Status bits 5 and 4 remain set through any other command until code 0x50 (given with no setup pending) or reset clears them. Code 0x50 leaves every other status bit and the read source as they were.
- R6: 0xBC followed by 0xD0 pulses blank_req with blank_addr equal to the address of the second write.
- R7: 0xC0 followed by any write pulses otp_req with otp_addr and otp_data taken from that second write.
- R8: 0xB0 while eng_busy is high and nothing is suspended pulses susp_req. The status then shows bit 7 set together with bit 2 for a program (eng_is_erase = 0) or bit 6 for an erase (eng_is_erase = 1).
- R9: A suspended state persists whatever eng_busy, eng_is_erase or other commands do. It ends only through 0xD0 given with no setup pending, which pulses resume_req and clears bits 6 and 2, or through reset.
- R10: With no setup pending, any code other than 0x60, 0xBC, 0xC0, 0x50, 0x70 and 0xFF has no effect on requests, status or read source. This includes 0xB0 while the engine is idle and 0xD0 while nothing is suspended.
- R11: 0xFF selects array reads. 0x70 and each of the setup codes 0x60, 0xBC and 0xC0 select status reads.
- R12: While nothing is suspended, status bit 7 equals the inverse of eng_busy. Status bits 3, 1 and 0 always read 0.
- R13: Each write produces at most one request, and every request output is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write cycle strobe, one cycle per write |
| wr_addr | input | ADDR_W | Address of the write |
| wr_data | input | DATA_W | Write data; bits [7:0] carry the command code |
| eng_busy | input | 1 | Write engine running a program or erase |
| eng_is_erase | input | 1 | Current engine operation is an erase |
| status | output | 8 | Status byte |
| rd_status | output | 1 | 1: reads return status, 0: reads return array data |
| lock_req | output | 1 | Protection change request pulse |
| lock_op | output | 2 | Protection operation code |
| lock_addr | output | ADDR_W | Block address for the protection change |
| rcr_wr | output | 1 | Read-configuration write pulse |
| rcr_val | output | 16 | New read-configuration value |
| blank_req | output | 1 | Blank check request pulse |
| blank_addr | output | ADDR_W | Block address for the blank check |
| otp_req | output | 1 | One-time/lock register program request pulse |
| otp_addr | output | ADDR_W | Register address for that program |
| otp_data | output | DATA_W | Data to program |
| susp_req | output | 1 | Suspend request pulse to the engine |
| resume_req | output | 1 | Resume request pulse to the engine |

## Verification
On every cycle the assertions check that the two error bits move together and fall only after a clear command, that a suspend bit is never shown without ready, and that the two suspend kinds exclude each other. They also check that the suspended state holds until a resume event, and that requests stay one-hot and single-cycle. Which follow-on code selects which operation, the address bits latched into each request, and the ignoring of stray codes can only be shown by the bench. It sweeps every possible byte as a second cycle after each setup code and as a lone command, and it runs suspend and resume with the engine inputs changing underneath.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CODE_CFG_SETUP   = 8'h60;
  localparam logic [7:0] CODE_PROT_LOCK   = 8'h01;
  localparam logic [7:0] CODE_PROT_UNLOCK = 8'hD0;
  localparam logic [7:0] CODE_PROT_DOWN   = 8'h2F;
  localparam logic [7:0] CODE_RCR_SET     = 8'h03;
  localparam logic [7:0] CODE_BLANK_SETUP = 8'hBC;
  localparam logic [7:0] CODE_CONFIRM     = 8'hD0;
  localparam logic [7:0] CODE_OTP_SETUP   = 8'hC0;
  localparam logic [7:0] CODE_SUSPEND     = 8'hB0;
  localparam logic [7:0] CODE_RESUME      = 8'hD0;
  localparam logic [7:0] CODE_CLEAR_ERR   = 8'h50;
  localparam logic [7:0] CODE_RD_ARRAY    = 8'hFF;
  localparam logic [7:0] CODE_RD_STATUS   = 8'h70;

  localparam int SB_READY = 7;
  localparam int SB_ESUSP = 6;
  localparam int SB_ERRH  = 5;
  localparam int SB_ERRL  = 4;
  localparam int SB_PSUSP = 2;

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_CFG,
    PEND_BLANK,
    PEND_OTP
  } pend_e;

  typedef enum logic [3:0] {
    ACT_NONE,
    ACT_SETUP_CFG,
    ACT_SETUP_BLANK,
    ACT_SETUP_OTP,
    ACT_LOCK,
    ACT_RCR,
    ACT_BLANK,
    ACT_OTP,
    ACT_SEQERR,
    ACT_SUSPEND,
    ACT_RESUME,
    ACT_CLEAR,
    ACT_RD_ARRAY,
    ACT_RD_STATUS
  } act_e;

  function automatic act_e classify(input pend_e pend, input logic [7:0] code,
                                    input logic busy, input logic susp);
    act_e r;
    r = ACT_NONE;
    case (pend)
      PEND_CFG: begin
        if (code == CODE_PROT_LOCK || code == CODE_PROT_UNLOCK || code == CODE_PROT_DOWN)
          r = ACT_LOCK;
        else if (code == CODE_RCR_SET)
          r = ACT_RCR;
        else
          r = ACT_SEQERR;
      end
      PEND_BLANK: r = (code == CODE_CONFIRM) ? ACT_BLANK : ACT_SEQERR;
      PEND_OTP:   r = ACT_OTP;
      default: begin
        case (code)
          CODE_CFG_SETUP:   r = ACT_SETUP_CFG;
          CODE_BLANK_SETUP: r = ACT_SETUP_BLANK;
          CODE_OTP_SETUP:   r = ACT_SETUP_OTP;
          CODE_SUSPEND:     r = (busy && !susp) ? ACT_SUSPEND : ACT_NONE;
          CODE_RESUME:      r = susp ? ACT_RESUME : ACT_NONE;
          CODE_CLEAR_ERR:   r = ACT_CLEAR;
          CODE_RD_ARRAY:    r = ACT_RD_ARRAY;
          CODE_RD_STATUS:   r = ACT_RD_STATUS;
          default:          r = ACT_NONE;
        endcase
      end
    endcase
    return r;
  endfunction

  function automatic pend_e next_pend(input act_e a);
    case (a)
      ACT_SETUP_CFG:   return PEND_CFG;
      ACT_SETUP_BLANK: return PEND_BLANK;
      ACT_SETUP_OTP:   return PEND_OTP;
      default:         return PEND_NONE;
    endcase
  endfunction

  function automatic logic [1:0] prot_op(input logic [7:0] code);
    case (code)
      CODE_PROT_LOCK:   return 2'b01;
      CODE_PROT_UNLOCK: return 2'b10;
      CODE_PROT_DOWN:   return 2'b11;
      default:          return 2'b00;
    endcase
  endfunction

  function automatic logic [15:0] rcr_field(input logic [31:0] addr);
    return addr[16:1];
  endfunction

  function automatic logic [7:0] pack_status(input logic ready, input logic esusp,
                                             input logic err, input logic psusp);
    logic [7:0] s;
    s = 8'h00;
    s[SB_READY] = ready;
    s[SB_ESUSP] = esusp;
    s[SB_ERRH]  = err;
    s[SB_ERRL]  = err;
    s[SB_PSUSP] = psusp;
    return s;
  endfunction

  function automatic logic selects_status(input act_e a, input logic cur);
    case (a)
      ACT_SETUP_CFG, ACT_SETUP_BLANK, ACT_SETUP_OTP, ACT_LOCK, ACT_BLANK,
      ACT_OTP, ACT_SEQERR, ACT_SUSPEND, ACT_RESUME, ACT_RD_STATUS: return 1'b1;
      ACT_RCR, ACT_RD_ARRAY: return 1'b0;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/fcd_seq_tracker.sv
module fcd_seq_tracker
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] code,
  input  logic       busy,
  input  logic       suspended,
  output act_e       act,
  output pend_e      pend
);

  pend_e pend_q;

  always_comb begin
    if (wr_en) act = classify(pend_q, code, busy, suspended);
    else       act = ACT_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= PEND_NONE;
    else if (wr_en) pend_q <= next_pend(act);
  end

  assign pend = pend_q;

endmodule

// File: rtl/fcd_suspend_ctl.sv
module fcd_suspend_ctl
  import flash_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  act_e act,
  input  logic eng_is_erase,
  output logic active,
  output logic kind_erase
);

  logic active_q;
  logic erase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      erase_q  <= 1'b0;
    end else if (act == ACT_SUSPEND) begin
      active_q <= 1'b1;
      erase_q  <= eng_is_erase;
    end else if (act == ACT_RESUME) begin
      active_q <= 1'b0;
      erase_q  <= 1'b0;
    end
  end

  assign active     = active_q;
  assign kind_erase = erase_q;

endmodule

// File: rtl/fcd_status_unit.sv
module fcd_status_unit
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  act_e       act,
  input  logic       eng_busy,
  input  logic       susp_active,
  input  logic       susp_erase,
  output logic [7:0] status,
  output logic       rd_status
);

  logic err_q;
  logic rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      if (act == ACT_SEQERR)      err_q <= 1'b1;
      else if (act == ACT_CLEAR)  err_q <= 1'b0;
      rd_q <= selects_status(act, rd_q);
    end
  end

  assign status = pack_status(susp_active | ~eng_busy,
                              susp_active & susp_erase,
                              err_q,
                              susp_active & ~susp_erase);
  assign rd_status = rd_q;

endmodule

// File: rtl/fcd_req_issue.sv
module fcd_req_issue
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_e              act,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              lock_req,
  output logic [1:0]        lock_op,
  output logic [ADDR_W-1:0] lock_addr,
  output logic              rcr_wr,
  output logic [15:0]       rcr_val,
  output logic              blank_req,
  output logic [ADDR_W-1:0] blank_addr,
  output logic              otp_req,
  output logic [ADDR_W-1:0] otp_addr,
  output logic [DATA_W-1:0] otp_data,
  output logic              susp_req,
  output logic              resume_req
);

  localparam int EXT_W = 32;

  logic [EXT_W-1:0] addr_ext;
  assign addr_ext = EXT_W'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_req   <= 1'b0;
      lock_op    <= 2'b00;
      lock_addr  <= '0;
      rcr_wr     <= 1'b0;
      rcr_val    <= '0;
      blank_req  <= 1'b0;
      blank_addr <= '0;
      otp_req    <= 1'b0;
      otp_addr   <= '0;
      otp_data   <= '0;
      susp_req   <= 1'b0;
      resume_req <= 1'b0;
    end else begin
      lock_req   <= (act == ACT_LOCK);
      rcr_wr     <= (act == ACT_RCR);
      blank_req  <= (act == ACT_BLANK);
      otp_req    <= (act == ACT_OTP);
      susp_req   <= (act == ACT_SUSPEND);
      resume_req <= (act == ACT_RESUME);
      if (act == ACT_LOCK) begin
        lock_op   <= prot_op(data[7:0]);
        lock_addr <= addr;
      end
      if (act == ACT_RCR)   rcr_val    <= rcr_field(addr_ext);
      if (act == ACT_BLANK) blank_addr <= addr;
      if (act == ACT_OTP) begin
        otp_addr <= addr;
        otp_data <= data;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              eng_busy,
  input  logic              eng_is_erase,
  output logic [7:0]        status,
  output logic              rd_status,
  output logic              lock_req,
  output logic [1:0]        lock_op,
  output logic [ADDR_W-1:0] lock_addr,
  output logic              rcr_wr,
  output logic [15:0]       rcr_val,
  output logic              blank_req,
  output logic [ADDR_W-1:0] blank_addr,
  output logic              otp_req,
  output logic [ADDR_W-1:0] otp_addr,
  output logic [DATA_W-1:0] otp_data,
  output logic              susp_req,
  output logic              resume_req
);

  act_e  act;
  pend_e pend;
  logic  susp_active;
  logic  susp_erase;

  logic evt_resume;
  logic evt_seq_err;
  logic evt_clear;

  fcd_seq_tracker u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .code      (wr_data[7:0]),
    .busy      (eng_busy),
    .suspended (susp_active),
    .act       (act),
    .pend      (pend)
  );

  fcd_suspend_ctl u_susp (
    .clk          (clk),
    .rst_n        (rst_n),
    .act          (act),
    .eng_is_erase (eng_is_erase),
    .active       (susp_active),
    .kind_erase   (susp_erase)
  );

  fcd_status_unit u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .act         (act),
    .eng_busy    (eng_busy),
    .susp_active (susp_active),
    .susp_erase  (susp_erase),
    .status      (status),
    .rd_status   (rd_status)
  );

  fcd_req_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (act),
    .addr       (wr_addr),
    .data       (wr_data),
    .lock_req   (lock_req),
    .lock_op    (lock_op),
    .lock_addr  (lock_addr),
    .rcr_wr     (rcr_wr),
    .rcr_val    (rcr_val),
    .blank_req  (blank_req),
    .blank_addr (blank_addr),
    .otp_req    (otp_req),
    .otp_addr   (otp_addr),
    .otp_data   (otp_data),
    .susp_req   (susp_req),
    .resume_req (resume_req)
  );

  assign evt_resume  = (act == ACT_RESUME);
  assign evt_seq_err = (act == ACT_SEQERR);
  assign evt_clear   = (act == ACT_CLEAR);

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status,
  input logic       rd_status,
  input logic       lock_req,
  input logic [1:0] lock_op,
  input logic       rcr_wr,
  input logic       blank_req,
  input logic       otp_req,
  input logic       susp_req,
  input logic       resume_req,
  input logic       susp_active,
  input logic       evt_resume,
  input logic       evt_seq_err,
  input logic       evt_clear
);

  assert_one_request_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lock_req, rcr_wr, blank_req, otp_req, susp_req, resume_req}));

  assert_single_cycle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_req | rcr_wr | blank_req | otp_req) |=> !(lock_req | rcr_wr | blank_req | otp_req));

  assert_err_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] == status[4]);

  assert_seq_err_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_seq_err |=> (status[5] && status[4]));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[5]) |-> $past(evt_clear));

  assert_susp_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] || status[6]) |-> status[7]);

  assert_susp_kind_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[2] && status[6]));

  assert_susp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_active && !evt_resume) |=> susp_active);

  assert_rcr_array_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rcr_wr |-> !rd_status);

  assert_lock_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_req |-> (lock_op != 2'b00));

endmodule

bind flash_cmd_decoder fcd_checker u_fcd_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .status      (status),
  .rd_status   (rd_status),
  .lock_req    (lock_req),
  .lock_op     (lock_op),
  .rcr_wr      (rcr_wr),
  .blank_req   (blank_req),
  .otp_req     (otp_req),
  .susp_req    (susp_req),
  .resume_req  (resume_req),
  .susp_active (susp_active),
  .evt_resume  (evt_resume),
  .evt_seq_err (evt_seq_err),
  .evt_clear   (evt_clear)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;

  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          eng_busy = 1'b0;
  logic          eng_is_erase = 1'b0;
  logic [7:0]    status;
  logic          rd_status;
  logic          lock_req;
  logic [1:0]    lock_op;
  logic [AW-1:0] lock_addr;
  logic          rcr_wr;
  logic [15:0]   rcr_val;
  logic          blank_req;
  logic [AW-1:0] blank_addr;
  logic          otp_req;
  logic [AW-1:0] otp_addr;
  logic [DW-1:0] otp_data;
  logic          susp_req;
  logic          resume_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_busy(eng_busy), .eng_is_erase(eng_is_erase), .status(status),
    .rd_status(rd_status), .lock_req(lock_req), .lock_op(lock_op),
    .lock_addr(lock_addr), .rcr_wr(rcr_wr), .rcr_val(rcr_val),
    .blank_req(blank_req), .blank_addr(blank_addr), .otp_req(otp_req),
    .otp_addr(otp_addr), .otp_data(otp_data), .susp_req(susp_req),
    .resume_req(resume_req)
  );

  function automatic logic [5:0] req_vec();
    return {lock_req, rcr_wr, blank_req, otp_req, susp_req, resume_req};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drives one write; returns at the following negedge, where the registered
  // result of that write is visible
  task automatic wr(input logic [7:0] code, input logic [AW-1:0] a,
                    input logic [7:0] hi);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = {hi, code};
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check(status == 8'h80, "R1", "status after reset", status, 8'h80);
    check(rd_status == 1'b0, "R1", "read source after reset", rd_status, 0);
    check(req_vec() == 6'd0, "R1", "requests after reset", req_vec(), 0);

    // Sweep every second-cycle byte after 0x60 (R2, R3, R4)
    for (int c = 0; c < 256; c++) begin
      logic [7:0]  code;
      logic [AW-1:0] a;
      logic [1:0]  eop;
      bit is_lock, is_rcr;
      code = 8'(c);
      a = {code ^ 8'h5A, ~code, code};
      is_lock = (code == 8'h01) || (code == 8'hD0) || (code == 8'h2F);
      is_rcr  = (code == 8'h03);
      eop = (code == 8'h01) ? 2'b01 : (code == 8'hD0) ? 2'b10 : 2'b11;
      do_reset();
      wr(8'h60, 24'h000000, 8'h00);
      check(rd_status == 1'b1, "R11", "read source after 0x60", rd_status, 1);
      wr(code, a, 8'h00);
      if (is_lock) begin
        check(lock_req && lock_op == eop && lock_addr == a && req_vec() == 6'b100000,
              "R2", "lock request", {lock_req, lock_op, lock_addr}, {1'b1, eop, a});
        check(status == 8'h80 && rd_status, "R2", "status/read after lock",
              {rd_status, status}, 9'h180);
      end else if (is_rcr) begin
        check(rcr_wr && rcr_val == a[16:1] && req_vec() == 6'b010000,
              "R3", "config write", {rcr_wr, rcr_val}, {1'b1, a[16:1]});
        check(status == 8'h80 && !rd_status, "R3", "status/read after config",
              {rd_status, status}, 9'h080);
      end else begin
        check(req_vec() == 6'd0, "R4", "no request on bad follow-on", req_vec(), 0);
        check(status == 8'hB0 && rd_status, "R4", "error status",
              {rd_status, status}, 9'h1B0);
      end
      idle_cycle();
      check(req_vec() == 6'd0, "R13", "request lasts one cycle", req_vec(), 0);
    end

    // Sweep every second-cycle byte after 0xBC (R6, R4)
    for (int c = 0; c < 256; c++) begin
      logic [7:0] code;
      logic [AW-1:0] a;
      code = 8'(c);
      a = {~code, code, code ^ 8'hC3};
      do_reset();
      wr(8'hBC, 24'h000000, 8'h00);
      wr(code, a, 8'h00);
      if (code == 8'hD0)
        check(blank_req && blank_addr == a && req_vec() == 6'b001000 && status == 8'h80,
              "R6", "blank check", {blank_req, blank_addr}, {1'b1, a});
      else
        check(req_vec() == 6'd0 && status == 8'hB0 && rd_status, "R4",
              "blank bad confirm", {req_vec(), status}, {6'd0, 8'hB0});
    end

    // Sweep every lone byte from reset (R10, R11)
    for (int c = 0; c < 256; c++) begin
      logic [7:0] code;
      bit exp_rd;
      code = 8'(c);
      exp_rd = (code == 8'h70) || (code == 8'h60) || (code == 8'hBC) || (code == 8'hC0);
      do_reset();
      wr(code, 24'h00ABCD, 8'h00);
      check(req_vec() == 6'd0 && status == 8'h80, "R10", "lone code has no side effect",
            {req_vec(), status}, {6'd0, 8'h80});
      check(rd_status == exp_rd, "R11", "read source for lone code", rd_status, exp_rd);
    end

    // OTP program (R7)
    for (int k = 0; k < 8; k++) begin
      logic [AW-1:0] a;
      logic [15:0] d;
      a = AW'(32'h00100 * k + 32'h37 * k);
      d = 16'(16'h1111 * k + 16'h0F);
      do_reset();
      wr(8'hC0, 24'h0, 8'h00);
      wr(d[7:0], a, d[15:8]);
      check(otp_req && otp_addr == a && otp_data == d && req_vec() == 6'b000100,
            "R7", "otp request", {otp_req, otp_addr, otp_data}, {1'b1, a, d});
    end

    // Error persistence and clear (R5)
    do_reset();
    wr(8'h60, 24'h0, 8'h00);
    wr(8'h77, 24'h0, 8'h00);
    wr(8'hFF, 24'h0, 8'h00);
    wr(8'h70, 24'h0, 8'h00);
    wr(8'h60, 24'h0, 8'h00);
    wr(8'h01, 24'h000400, 8'h00);
    check(status == 8'hB0, "R5", "error kept through other commands", status, 8'hB0);
    wr(8'hFF, 24'h0, 8'h00);
    wr(8'h50, 24'h0, 8'h00);
    check(status == 8'h80 && !rd_status, "R5", "clear drops error only",
          {rd_status, status}, 9'h080);
    wr(8'hBC, 24'h0, 8'h00);
    wr(8'h01, 24'h0, 8'h00);
    do_reset();
    check(status == 8'h80, "R5", "reset clears error", status, 8'h80);

    // Ready tracks engine (R12)
    eng_busy = 1'b1;
    idle_cycle();
    check(status == 8'h00, "R12", "busy engine drops ready", status, 8'h00);

    // Program suspend (R8, R9)
    eng_is_erase = 1'b0;
    wr(8'hB0, 24'h0, 8'h00);
    check(susp_req && status == 8'h84 && rd_status, "R8", "program suspend",
          {susp_req, status}, {1'b1, 8'h84});
    eng_busy = 1'b0;
    eng_is_erase = 1'b1;
    wr(8'hFF, 24'h0, 8'h00);
    wr(8'hB0, 24'h0, 8'h00);
    check(status == 8'h84 && !susp_req, "R9", "suspend holds", status, 8'h84);
    eng_busy = 1'b1;
    wr(8'h60, 24'h0, 8'h00);
    wr(8'hD0, 24'h000200, 8'h00);
    check(lock_req && !resume_req && status == 8'h84, "R9", "confirm is not resume",
          {lock_req, resume_req, status}, {2'b10, 8'h84});
    wr(8'hD0, 24'h0, 8'h00);
    check(resume_req && status == 8'h00, "R9", "resume clears suspend",
          {resume_req, status}, {1'b1, 8'h00});

    // Erase suspend and reset exit (R8, R9)
    eng_is_erase = 1'b1;
    wr(8'hB0, 24'h0, 8'h00);
    check(susp_req && status == 8'hC0, "R8", "erase suspend", {susp_req, status}, {1'b1, 8'hC0});
    eng_busy = 1'b0;
    do_reset();
    check(status == 8'h80 && req_vec() == 6'd0, "R9", "reset exits suspend", status, 8'h80);
    wr(8'hD0, 24'h0, 8'h00);
    check(!resume_req, "R10", "resume with nothing suspended ignored", resume_req, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule